// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block is a watchdog for a processor subsystem. A tick enable, in the same clock domain as the write port, stands for the counting clock. The tick first passes through a fixed prescaler and then drives a down-counter. Software writes a reload constant, picks the underflow action, and starts the timer. While the timer runs, software must write a 16-bit key word to the feed register before the counter runs out. If it does not, the block either pulses a reset request for one clock or sets an interrupt flag that stays set until software clears it.

Software reaches the block through a plain write strobe, a 2-bit register select and a 16-bit data word:

| Select | Register | Data field |
|--------|----------|------------|
| 0 | Control | bit 0 = run, bit 1 = action (0 = reset, 1 = interrupt) |
| 1 | Reload | bits CNT_W-1:0 |
| 2 | Feed | the whole 16-bit word is compared with the key |
| 3 | Flag clear | bit 0 = 1 clears the flag |

The live counter value is brought out for observation. The prescale ratio must be at least 2.

Top module: `kfwdt_top`

## Requirements
- R1: After reset, `rst_req` and `irq_flag` are 0, `cnt` is 0, the timer is stopped, and the reload register holds all ones, so a first start without a reload write loads 255.
- R2: While the timer runs, the counter drops by one each time PRE_DIV tick enables have been seen. While `tick_en` is low, the counter and the prescaler hold.
- R3: The timeout is (reload + 1) × PRE_DIV ticks from the start. A reload of 0 gives PRE_DIV ticks, and a reload of 255 gives 256 × PRE_DIV ticks.
- R4: A control write that sets bit 0 while the timer is stopped loads the counter from the reload register and clears the prescaler. The same write while the timer already runs does not reload the counter.
- R5: A feed write (select 2) of exactly KEY (default 0x55AA) while the timer runs reloads the counter, clears the prescaler and starts a full new interval.
- R6: A feed write of any other value changes neither the counter nor the prescaler.
- R7: In reset action (control bit 1 = 0), an underflow raises `rst_req` for exactly one clock.
- R8: In interrupt action (control bit 1 = 1), an underflow sets `irq_flag` and never raises `rst_req`. The flag stays set, and the counter reloads and keeps running.
- R9: A select-3 write with bit 0 = 1 clears `irq_flag`, and one with bit 0 = 0 leaves it set. A new underflow in the same clock as a clear wins, and the flag stays set.
- R10: A control write with bit 0 = 0 stops the timer. The counter then holds its value and no reset request or interrupt occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the register port and the counting logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Counting-clock enable, fed into the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 reload, 2 feed, 3 flag clear |
| wr_data | input | 16 | Write data |
| rst_req | output | 1 | One-clock reset request on an underflow in reset action |
| irq_flag | output | 1 | Sticky interrupt flag set on an underflow in interrupt action |
| cnt | output | CNT_W | Current counter value |

## Verification
The bench builds the block with PRE_DIV = 4 and keeps CNT_W = 8 and the 0x55AA key. The short prescale makes the full 256-step timeout take only 1024 clocks. This leaves room in the run for both extreme timeouts, for repeated interrupt periods, and for feeds and flag clears placed on exact cycles relative to an underflow. With the full 8-bit counter, the decrement steps and the wrap on underflow are the same as at the default ratio, so nothing in the counter logic is scaled down.

// File: rtl/kfwdt_pkg.sv
package kfwdt_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_FEED   = 2'd2,
        SEL_CLEAR  = 2'd3
    } kf_sel_e;

    typedef enum logic {
        MODE_RESET = 1'b0,
        MODE_IRQ   = 1'b1
    } kf_mode_e;

endpackage

// File: rtl/kfwdt_regs.sv
module kfwdt_regs
    import kfwdt_pkg::*;
#(
    parameter int          CNT_W  = 8,
    parameter int          DATA_W = 16,
    parameter logic [15:0] KEY    = 16'h55AA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              run_o,
    output kf_mode_e          mode_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              load_o,
    output logic              clr_flag_o
);

    localparam logic [DATA_W-1:0] KEY_W = DATA_W'(KEY);

    typedef struct packed {
        logic             run;
        kf_mode_e         mode;
        logic [CNT_W-1:0] reload;
    } regs_t;

    regs_t s_d, s_q;
    logic  load_d, clr_d;

    always_comb begin
        s_d    = s_q;
        load_d = 1'b0;
        clr_d  = 1'b0;
        if (wr_en) begin
            case (kf_sel_e'(wr_sel))
                SEL_CTRL: begin
                    s_d.run  = wr_data[0];
                    s_d.mode = kf_mode_e'(wr_data[1]);
                    load_d   = wr_data[0] && !s_q.run;
                end
                SEL_RELOAD: s_d.reload = wr_data[CNT_W-1:0];
                SEL_FEED:   load_d = s_q.run && (wr_data == KEY_W);
                SEL_CLEAR:  clr_d  = wr_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.run    <= 1'b0;
            s_q.mode   <= MODE_RESET;
            s_q.reload <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign run_o      = s_q.run;
    assign mode_o     = s_q.mode;
    assign reload_o   = s_q.reload;
    assign load_o     = load_d;
    assign clr_flag_o = clr_d;

    // R4: the timer only goes from stopped to running on a cycle that loaded the counter
    p_start_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !$past(s_q.run)) |-> $past(load_d));

    // R10: a stopped timer ignores feed writes
    p_no_feed_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.run && wr_en && (kf_sel_e'(wr_sel) == SEL_FEED)) |-> !load_o);

endmodule

// File: rtl/kfwdt_prescale.sv
module kfwdt_prescale #(
    parameter int PRE_DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    input  logic clear_i,
    output logic strobe_o
);

    localparam int             PW   = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PW-1:0]  LAST = PW'(PRE_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
    } pre_t;

    pre_t s_d, s_q;
    logic wrap;

    always_comb begin
        s_d  = s_q;
        wrap = run_i && tick_i && !clear_i && (s_q.pre == LAST);
        if (clear_i) begin
            s_d.pre = '0;
        end else if (run_i && tick_i) begin
            s_d.pre = (s_q.pre == LAST) ? '0 : s_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.pre <= '0;
        else        s_q <= s_d;
    end

    assign strobe_o = wrap;

    p_pre_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pre <= LAST);

    p_pre_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (s_q.pre == '0));

    p_pre_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clear_i) |=> $stable(s_q.pre));

endmodule

// File: rtl/kfwdt_counter.sv
module kfwdt_counter
    import kfwdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             strobe_i,
    input  kf_mode_e         mode_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             clr_flag_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             rst_req_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rst_req;
        logic             irq;
    } cnt_t;

    cnt_t s_d, s_q;
    logic uf;

    always_comb begin
        s_d         = s_q;
        uf          = strobe_i && (s_q.cnt == '0);
        s_d.rst_req = uf && (mode_i == MODE_RESET);
        if (load_i) begin
            s_d.cnt = reload_i;
        end else if (strobe_i) begin
            s_d.cnt = uf ? reload_i : s_q.cnt - 1'b1;
        end
        if (uf && (mode_i == MODE_IRQ)) begin
            s_d.irq = 1'b1;
        end else if (clr_flag_i) begin
            s_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt     <= '0;
            s_q.rst_req <= 1'b0;
            s_q.irq     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o     = s_q.cnt;
    assign rst_req_o = s_q.rst_req;
    assign irq_o     = s_q.irq;

    p_dec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && !load_i && (cnt_o != '0)) |=> (cnt_o == CNT_W'($past(cnt_o) - 1'b1)));

    p_load_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_o == $past(reload_i)));

    p_rst_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> ($past(strobe_i) && ($past(mode_i) == MODE_RESET)));

    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_flag_i) |=> irq_o);

endmodule

// File: rtl/kfwdt_top.sv
module kfwdt_top
    import kfwdt_pkg::*;
#(
    parameter int          PRE_DIV = 128,
    parameter int          CNT_W   = 8,
    parameter logic [15:0] KEY     = 16'h55AA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [15:0]      wr_data,
    output logic             rst_req,
    output logic             irq_flag,
    output logic [CNT_W-1:0] cnt
);

    localparam int DATA_W = 16;

    logic             run;
    kf_mode_e         mode;
    logic [CNT_W-1:0] reload;
    logic             load;
    logic             clr_flag;
    logic             strobe;

    kfwdt_regs #(
        .CNT_W (CNT_W),
        .DATA_W(DATA_W),
        .KEY   (KEY)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .run_o     (run),
        .mode_o    (mode),
        .reload_o  (reload),
        .load_o    (load),
        .clr_flag_o(clr_flag)
    );

    kfwdt_prescale #(
        .PRE_DIV(PRE_DIV)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .tick_i  (tick_en),
        .clear_i (load),
        .strobe_o(strobe)
    );

    kfwdt_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .strobe_i  (strobe),
        .mode_i    (mode),
        .reload_i  (reload),
        .clr_flag_i(clr_flag),
        .cnt_o     (cnt),
        .rst_req_o (rst_req),
        .irq_o     (irq_flag)
    );

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt));

    p_stopped_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !rst_req);

    p_irq_no_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(mode) == MODE_RESET));

endmodule

// File: tb/test_kfwdt_top.sv
`timescale 1ns/1ps
module test_kfwdt_top;

    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic       rst_req, irq_flag;
    logic [7:0] cnt;

    always #2.5 clk = ~clk;

    kfwdt_top #(.PRE_DIV(P), .CNT_W(8), .KEY(16'h55AA)) i_kfwdt_top (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rst_req(rst_req),
        .irq_flag(irq_flag), .cnt(cnt)
    );

    typedef struct { int cyc; bit is_irq; string tag; } ev_t;
    ev_t exp_q[$];

    int  cyc = 0;
    int  n_cmp = 0;
    int  n_bad = 0;
    bit  irq_prev = 1'b0;
    bit  done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input int act, input int exp, input string tag);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic push(input int c, input bit irq, input string tag);
        ev_t e;
        e.cyc = c; e.is_irq = irq; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compares every observed event against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ev_r, ev_i;
            ev_r = rst_req;
            ev_i = irq_flag && !irq_prev;
            irq_prev = irq_flag;
            while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
                n_cmp++; n_bad++;
                $display("FAIL %s: event missing, actual none expected cycle %0d",
                         exp_q[0].tag, exp_q[0].cyc);
                void'(exp_q.pop_front());
            end
            if (ev_r || ev_i) begin
                n_cmp++;
                if (exp_q.size() == 0 || exp_q[0].cyc != cyc || exp_q[0].is_irq != ev_i) begin
                    n_bad++;
                    $display("FAIL %s: event irq=%0d at cycle %0d, expected cycle %0d",
                             (exp_q.size() > 0) ? exp_q[0].tag : "R7/R8/R10",
                             ev_i, cyc, (exp_q.size() > 0) ? exp_q[0].cyc : -1);
                end else begin
                    void'(exp_q.pop_front());
                end
            end
        end
    end

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #100000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        int L, F, held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rst_req, 0, "R1 rst_req");
        chk(irq_flag, 0, "R1 irq_flag");
        chk(cnt, 0, "R1 cnt");
        wr(2'd0, 16'h0001);
        chk(cnt, 255, "R1 default reload");
        wr(2'd0, 16'h0000);

        // R3 shortest timeout, R7 one-clock reset pulse
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h0001);
        L = cyc;
        push(L + P, 1'b0, "R3 min timeout");
        wait_to(L + P + 1);
        wr(2'd0, 16'h0000);
        // R10 stopped timer holds and stays quiet
        held = cnt;
        wait_to(cyc + 20);
        chk(cnt, held, "R10 hold when stopped");

        // R3 longest timeout, R2 decrement cadence
        wr(2'd1, 16'h00FF);
        wr(2'd0, 16'h0001);
        L = cyc;
        push(L + 256 * P, 1'b0, "R3 max timeout");
        chk(cnt, 255, "R4 start loads");
        wait_to(L + P - 1);
        chk(cnt, 255, "R2 before prescale wrap");
        wait_to(L + P);
        chk(cnt, 254, "R2 one step per prescale");
        wait_to(L + 256 * P + 1);
        wr(2'd0, 16'h0000);

        // R5 feed, R6 wrong key, R4 enable while running
        wr(2'd1, 16'h0003);
        wr(2'd0, 16'h0001);
        L = cyc;
        wait_to(L + 6);
        wr(2'd2, 16'h55AB);
        chk(cnt, 2, "R6 wrong key ignored");
        wr(2'd0, 16'h0001);
        chk(cnt, 1, "R4 no reload while running");
        wait_to(L + 10);
        wr(2'd2, 16'hAA55);
        chk(cnt, 1, "R6 swapped key ignored");
        wr(2'd2, 16'h55AA);
        F = cyc;
        chk(cnt, 3, "R5 feed reloads");
        push(F + 4 * P, 1'b0, "R5 full interval after feed");
        wait_to(F + 4 * P + 1);
        wr(2'd0, 16'h0000);

        // R8 interrupt mode, R9 flag clear
        wr(2'd1, 16'h0001);
        wr(2'd0, 16'h0003);
        L = cyc;
        push(L + 2 * P, 1'b1, "R8 first irq");
        wait_to(L + 12);
        chk(irq_flag, 1, "R8 flag sticky");
        chk(rst_req, 0, "R8 no reset request");
        wr(2'd3, 16'h0001);
        chk(irq_flag, 0, "R9 clear");
        push(L + 16, 1'b1, "R8 counter keeps running");
        wait_to(L + 18);
        wr(2'd3, 16'h0001);
        chk(irq_flag, 0, "R9 clear again");
        push(L + 24, 1'b1, "R9 set beats clear");
        wait_to(L + 23);
        wr(2'd3, 16'h0001);
        chk(irq_flag, 1, "R9 set wins over clear");
        wr(2'd3, 16'h0000);
        chk(irq_flag, 1, "R9 zero bit does not clear");
        wr(2'd0, 16'h0000);
        wr(2'd3, 16'h0001);
        chk(irq_flag, 0, "R9 final clear");

        // R2 tick gating
        wr(2'd1, 16'h0002);
        wr(2'd0, 16'h0001);
        L = cyc;
        tick_en = 1'b0;
        wait_to(L + 30);
        chk(cnt, 2, "R2 hold without ticks");
        tick_en = 1'b1;
        push(L + 30 + 3 * P, 1'b0, "R2 resumes after ticks");
        wait_to(L + 30 + 3 * P + 1);
        wr(2'd0, 16'h0000);

        wait_to(cyc + 10);
        while (exp_q.size() > 0) begin
            n_cmp++; n_bad++;
            $display("FAIL %s: actual none expected event at cycle %0d",
                     exp_q[0].tag, exp_q[0].cyc);
            void'(exp_q.pop_front());
        end
        finish_run();
    end

endmodule